// File: doc/BRIEF.md
# Shared Active-Low Line Ownership Sequencer

This block controls one agent's connection to a shared, active-low bus line that several agents can drive, though only one may drive it at a time. The local logic asks for the line to be pulled low and later lets it go. The block turns those requests into a drive value and a separate output-enable for a bidirectional pad.

Two handover rules are enforced. When this agent gives the line up, it first drives it high for a fixed park period and only then stops driving. When it takes the line after another agent, it waits for a gap with nothing driven before it pulls the line low.

The block watches the sampled line to learn when another agent has been driving. A request made while the line is busy, or while this agent is still parking, is held until it can be served. Ownership is decided elsewhere and arrives as a single grant input. A one-cycle error pulse reports a park cycle in which the line was seen low even though this agent was driving it high.

Top module: `sts_line_ctrl`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) makes line_oe_o 0, line_out_o 1 and park_err_o 0 after that edge. It clears any held request. After reset the last driver is treated as another agent, so the first takeover includes the gap of R6.
- R2: The outputs encode the state as follows. Driving low is line_oe_o=1 with line_out_o=0. Parking is line_oe_o=1 with line_out_o=1. Floating is line_oe_o=0 with line_out_o=1.
- R3: While driving low, a release_req_i at a clock edge starts the park. The park lasts exactly PARK_CYCLES cycles (default 1), and floating follows it.
- R4: While driving low, grant_i low at a clock edge also starts the park of R3. The drive is never removed straight from low.
- R5: A takeover starts only at an edge where grant_i is 1 and line_in_i is 1. A request seen while either condition is false is held, not dropped.
- R6: The last driver is another agent if line_in_i was sampled 0 while this agent was not driving, or if reset came last. In that case a takeover first floats for GAP_CYCLES cycles (default 1) and then drives low.
- R7: If this agent was the last driver, a held or new request drives the line low in the cycle after the deciding edge, with no gap.
- R8: An assert_req_i that arrives during the park is held, and the line is driven low again once the park has ended.
- R9: A release_req_i cancels any held request, including one waiting in the gap. A release during the park does not change the park.
- R10: park_err_o is 1 for exactly the cycle after a park cycle in which line_in_i was sampled 0, and is 0 otherwise.
- R11: At the end of the gap, if grant_i is 0 or line_in_i is 0, the block returns to floating. It keeps the request and takes the gap again on its next try.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| grant_i | input | 1 | Ownership granted to this agent |
| assert_req_i | input | 1 | Local request to pull the line low |
| release_req_i | input | 1 | Local request to let the line go |
| line_in_i | input | 1 | Sampled level of the shared line |
| line_out_o | output | 1 | Value to drive onto the line |
| line_oe_o | output | 1 | Output-enable for the line driver |
| park_err_o | output | 1 | Pulse: line seen low during a park cycle |

## Verification
The coincidences that matter are a new local request landing in the park cycle, and the error check landing in the same park cycle as a grant loss. Both are provoked in the vector table by setting the inputs on exactly that cycle. The first is judged by the line going low again right after it floats. The second is judged by park_err_o rising with the float while the request and gap bookkeeping stay untouched. A release in the same cycle as an aborted gap or a held request is judged by the line staying floated on the following edges.

// File: rtl/sts_line_pkg.sv
package sts_line_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_TURN = 2'd1,
        ST_ASSERT    = 2'd2,
        ST_PARK_HIGH = 2'd3
    } sts_state_e;

    typedef struct packed {
        logic pend;
        logic other_last;
    } sts_track_t;

    typedef struct packed {
        logic err;
    } sts_drive_t;
endpackage

// File: rtl/sts_line_fsm.sv
module sts_line_fsm
    import sts_line_pkg::*;
#(
    parameter int PARK_CYCLES = 1,
    parameter int GAP_CYCLES  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       grant_i,
    input  logic       assert_req_i,
    input  logic       release_req_i,
    input  logic       line_in_i,
    input  logic       pend_i,
    input  logic       other_last_i,
    output sts_state_e state_o,
    output logic       to_assert_o
);
    localparam int MAXC = (PARK_CYCLES > GAP_CYCLES) ? PARK_CYCLES : GAP_CYCLES;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] PARK_LAST = CW'(PARK_CYCLES - 1);
    localparam logic [CW-1:0] GAP_LAST  = CW'(GAP_CYCLES - 1);

    typedef struct packed {
        sts_state_e    state;
        logic [CW-1:0] cnt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic want;

    always_comb begin
        fsm_d = fsm_q;
        want  = pend_i | assert_req_i;
        case (fsm_q.state)
            ST_IDLE: begin
                if (want && !release_req_i && grant_i && line_in_i) begin
                    fsm_d.cnt   = '0;
                    fsm_d.state = other_last_i ? ST_WAIT_TURN : ST_ASSERT;
                end
            end
            ST_WAIT_TURN: begin
                if (release_req_i) begin
                    fsm_d.state = ST_IDLE;
                end else if (fsm_q.cnt == GAP_LAST) begin
                    fsm_d.state = (grant_i && line_in_i) ? ST_ASSERT : ST_IDLE;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            ST_ASSERT: begin
                if (release_req_i || !grant_i) begin
                    fsm_d.state = ST_PARK_HIGH;
                    fsm_d.cnt   = '0;
                end
            end
            default: begin
                if (fsm_q.cnt == PARK_LAST) begin
                    fsm_d.state = ST_IDLE;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
        endcase
        if (!rst_n) begin
            fsm_d.state = ST_IDLE;
            fsm_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk) begin
        fsm_q <= fsm_d;
    end

    assign state_o     = fsm_q.state;
    assign to_assert_o = (fsm_d.state == ST_ASSERT);
endmodule

// File: rtl/sts_line_track.sv
module sts_line_track
    import sts_line_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic assert_req_i,
    input  logic release_req_i,
    input  logic line_in_i,
    input  logic driving_i,
    input  logic to_assert_i,
    output logic pend_o,
    output logic other_last_o
);
    sts_track_t trk_d, trk_q;

    always_comb begin
        trk_d      = trk_q;
        trk_d.pend = (trk_q.pend | assert_req_i) & ~release_req_i;
        if (!driving_i && !line_in_i) begin
            trk_d.other_last = 1'b1;
        end
        if (to_assert_i) begin
            trk_d.pend       = 1'b0;
            trk_d.other_last = 1'b0;
        end
        if (!rst_n) begin
            trk_d.pend       = 1'b0;
            trk_d.other_last = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        trk_q <= trk_d;
    end

    assign pend_o       = trk_q.pend;
    assign other_last_o = trk_q.other_last;
endmodule

// File: rtl/sts_line_drive.sv
module sts_line_drive
    import sts_line_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sts_state_e state_i,
    input  logic       line_in_i,
    output logic       line_out_o,
    output logic       line_oe_o,
    output logic       park_err_o
);
    sts_drive_t drv_d, drv_q;

    always_comb begin
        drv_d.err = (state_i == ST_PARK_HIGH) && !line_in_i;
        if (!rst_n) begin
            drv_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        drv_q <= drv_d;
    end

    assign line_oe_o  = (state_i == ST_ASSERT) || (state_i == ST_PARK_HIGH);
    assign line_out_o = (state_i != ST_ASSERT);
    assign park_err_o = drv_q.err;
endmodule

// File: rtl/sts_line_ctrl.sv
module sts_line_ctrl
    import sts_line_pkg::*;
#(
    parameter int PARK_CYCLES = 1,
    parameter int GAP_CYCLES  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_i,
    input  logic assert_req_i,
    input  logic release_req_i,
    input  logic line_in_i,
    output logic line_out_o,
    output logic line_oe_o,
    output logic park_err_o
);
    sts_state_e state;
    logic       to_assert;
    logic       pend;
    logic       other_last;

    sts_line_fsm #(
        .PARK_CYCLES(PARK_CYCLES),
        .GAP_CYCLES (GAP_CYCLES)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .grant_i      (grant_i),
        .assert_req_i (assert_req_i),
        .release_req_i(release_req_i),
        .line_in_i    (line_in_i),
        .pend_i       (pend),
        .other_last_i (other_last),
        .state_o      (state),
        .to_assert_o  (to_assert)
    );

    sts_line_track track_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .assert_req_i (assert_req_i),
        .release_req_i(release_req_i),
        .line_in_i    (line_in_i),
        .driving_i    (line_oe_o),
        .to_assert_i  (to_assert),
        .pend_o       (pend),
        .other_last_o (other_last)
    );

    sts_line_drive drive_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_i   (state),
        .line_in_i (line_in_i),
        .line_out_o(line_out_o),
        .line_oe_o (line_oe_o),
        .park_err_o(park_err_o)
    );
endmodule

// File: rtl/sts_line_chk.sv
module sts_line_chk #(
    parameter int PARK_CYCLES = 1
) (
    input logic clk,
    input logic rst_n,
    input logic grant_i,
    input logic line_in_i,
    input logic line_out_o,
    input logic line_oe_o,
    input logic park_err_o
);
    localparam int RW = $clog2(PARK_CYCLES + 2);
    logic [RW-1:0] park_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            park_run_q <= '0;
        end else if (line_oe_o && line_out_o) begin
            park_run_q <= park_run_q + 1'b1;
        end else begin
            park_run_q <= '0;
        end
    end

    // R3: the drive is removed only after exactly PARK_CYCLES high cycles
    a_r3_park_len: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(line_oe_o) && $past(rst_n)) |-> (park_run_q == RW'(PARK_CYCLES)));

    // R2: taking the line always begins by driving it low
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(line_oe_o) && $past(rst_n)) |-> !line_out_o);

    // R4: driving low needs the grant on the deciding edge
    a_r4_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe_o && !line_out_o) |-> $past(grant_i));

    // R10: error pulse follows a park cycle that saw the line low
    a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        park_err_o |-> $past(line_oe_o && line_out_o && !line_in_i));

    a_r10_err_seen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(line_oe_o && line_out_o && !line_in_i)) |-> park_err_o);
endmodule

bind sts_line_ctrl sts_line_chk #(.PARK_CYCLES(PARK_CYCLES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant_i   (grant_i),
    .line_in_i (line_in_i),
    .line_out_o(line_out_o),
    .line_oe_o (line_oe_o),
    .park_err_o(park_err_o)
);

// File: tb/sts_line_ctrl_tb.sv
`timescale 1ns/1ps
module sts_line_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grant_i = 1'b0;
    logic assert_req_i = 1'b0;
    logic release_req_i = 1'b0;
    logic line_in_i = 1'b1;
    logic line_out_o, line_oe_o, park_err_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sts_line_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .grant_i      (grant_i),
        .assert_req_i (assert_req_i),
        .release_req_i(release_req_i),
        .line_in_i    (line_in_i),
        .line_out_o   (line_out_o),
        .line_oe_o    (line_oe_o),
        .park_err_o   (park_err_o)
    );

    // {grant, assert_req, release_req, line_in, exp_oe, exp_out, exp_err}
    localparam int NV = 23;
    localparam logic [6:0] VEC [NV] = '{
        7'b1101_010, // 0  R6 gap first after reset
        7'b1001_100, // 1  R6 then drive low
        7'b1000_100, // 2  R2 hold low
        7'b1010_110, // 3  R3 release parks
        7'b1001_010, // 4  R3 float
        7'b1101_100, // 5  R7 own line, no gap
        7'b1010_110, // 6  R3 park
        7'b1101_010, // 7  R8 request during park
        7'b1001_100, // 8  R8 served after float
        7'b0000_110, // 9  R4 grant lost parks
        7'b0000_011, // 10 R10 low seen in park
        7'b0000_010, // 11 R10 single pulse
        7'b1100_010, // 12 R5 line busy, held
        7'b1001_010, // 13 R6 gap after other agent
        7'b1001_100, // 14 R6 drive low
        7'b1010_110, // 15 R3 park
        7'b1001_010, // 16 R3 float
        7'b0101_010, // 17 R5 no grant, held
        7'b0011_010, // 18 R9 release cancels
        7'b1001_010, // 19 R9 nothing left
        7'b1101_100, // 20 R7 direct takeover
        7'b1010_110, // 21 R3 park
        7'b1001_010  // 22 R3 float
    };
    localparam int VREQ [NV] = '{6,6,2,3,3,7,3,8,8,4,10,10,5,6,6,3,3,5,9,9,7,3,3};

    task automatic check(input logic eoe, input logic eout, input logic eerr, input int req);
        checks++;
        if (line_oe_o !== eoe || line_out_o !== eout || park_err_o !== eerr) begin
            failures++;
            $display("FAIL R%0d: oe/out/err actual %b%b%b expected %b%b%b",
                     req, line_oe_o, line_out_o, park_err_o, eoe, eout, eerr);
        end
    endtask

    task automatic step(input logic g, input logic a, input logic r, input logic l,
                        input logic eoe, input logic eout, input logic eerr, input int req);
        grant_i = g; assert_req_i = a; release_req_i = r; line_in_i = l;
        @(posedge clk);
        #1;
        check(eoe, eout, eerr, req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(1'b0, 1'b1, 1'b0, 1); // R1 reset state
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3],
                 VEC[i][2], VEC[i][1], VEC[i][0], VREQ[i]);
        end
        // R1: reset re-arms the gap rule
        rst_n = 1'b0;
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1);
        // R11: gap aborted by grant loss, request kept
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 11);
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 11);
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 11);
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11);
        // R9: release during park leaves the park alone
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 9);
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 9);
        // R1: reset while driving low
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 7);
        rst_n = 1'b0;
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1);
        rst_n = 1'b1;
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1);
        // R9: release in the gap cancels the request
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 9);
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 9);
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 9);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #20000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL R1: watchdog expired actual running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule